// File: doc/BRIEF.md
# Acknowledged raw-Ethernet frame sender

The block turns a stream of 32-bit words from on-chip logic into raw Ethernet frames. The frames carry a private EtherType and travel with no IP layer and no address resolution. The destination MAC is a fixed parameter that the receiving host associates with this device. Every frame carries a 16-bit sequence number and a fixed number of payload words. Those words stay in an on-chip buffer until the receiver acknowledges that sequence number.

Up to `WIN` frames may be outstanding at once. A frame occupies the slot given by the low bits of its sequence number and holds it until its acknowledge arrives. If no acknowledge comes within `TIMEOUT` cycles of the most recent transmission, the frame is sent again with the same number and payload. Two exported counters record all frame transmissions and the retransmissions among them, so a host or a local rate controller can raise the `gap_cycles` delay when retransmissions become frequent. When the input is a counter of consecutive integers, the receiver can verify continuity directly.

Both streams use valid/ready and follow the same rules.
- Output stream: a byte moves only in a cycle where `tx_valid` and `tx_ready` are both high. While `tx_valid` is high and `tx_ready` is low, `tx_data`, `tx_first` and `tx_last` hold their values.
- Input stream: a word is taken in a cycle where `din_valid` and `din_ready` are both high. `din_ready` goes low when the slot for the next sequence number is still outstanding, or when that frame's words are already complete.

Top module: `rft_ack_tx`

## Requirements
- R1: Every frame is 16 + 4·WORDS bytes, in this order: the destination MAC (6 bytes, most significant first), the source MAC (6 bytes), the type bytes 0xFA then 0xDE, the sequence number high byte then low byte, and then the payload words, each sent most significant byte first. `tx_first` is high only on byte 0 and `tx_last` is high only on the final byte.
- R2: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data`, `tx_first` and `tx_last` hold their values. A byte is transferred only when valid and ready are both high.
- R3: New frames take consecutive sequence numbers starting at 0 after reset. Frame n carries input words n·WORDS to n·WORDS+WORDS-1, in the order they were accepted.
- R4: At most WIN frames are outstanding. When the slot numbered seq mod WIN for the next sequence number is still outstanding, `din_ready` stays low and no new frame starts.
- R5: An acknowledge (`ack_vld` high with `ack_seq`) that matches an outstanding frame's sequence number retires that frame. Its slot is free on the next cycle.
- R6: An acknowledge whose number is not outstanding has no effect on the window, on `din_ready` or on the counters.
- R7: An outstanding frame with no acknowledge for TIMEOUT cycles after its latest transmission start is sent again with the same sequence number and payload. When the output is idle and ready, the first byte of the repeat appears TIMEOUT+1 cycles after the first byte of the previous transmission.
- R8: Let a frame's last byte be transferred in cycle c. The first byte of a new data frame then appears no earlier than cycle c + `gap_cycles` + 2, and exactly then when its data is complete.
- R9: `frames_sent` counts every frame start, whether new or repeated. `frames_resent` counts repeats only. Each increment comes with a one-cycle strobe on `sent_stb` or `resent_stb`, and a repeat pulses both strobes.
- R10: While `rst_n` is low at a clock edge, the block resets: `tx_valid` goes low, `din_ready` goes high and both counters go to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| din_valid | input | 1 | Input word valid |
| din_ready | output | 1 | Block can take an input word |
| din_data | input | 32 | Input word |
| ack_vld | input | 1 | Parsed acknowledge strobe |
| ack_seq | input | 16 | Acknowledged sequence number |
| gap_cycles | input | GAP_W | Idle cycles required before a new data frame |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | MAC accepts a byte |
| tx_data | output | 8 | Output byte |
| tx_first | output | 1 | First byte of a frame |
| tx_last | output | 1 | Last byte of a frame |
| frames_sent | output | CNT_W | Total frame transmissions |
| sent_stb | output | 1 | Pulse on each increment of frames_sent |
| frames_resent | output | CNT_W | Retransmissions |
| resent_stb | output | 1 | Pulse on each increment of frames_resent |

## Verification
The assertions assume that the MAC may hold `tx_ready` low for any length of time. They also assume that acknowledges arrive as single-cycle strobes, and that `gap_cycles` changes only between frames. The stimulus meets these assumptions: it drives all inputs on the falling edge, holds `ack_vld` for exactly one cycle and changes the gap setting only while no frame is near its end. Acknowledges are sent well inside the timeout except in the one test that lets a frame expire. The retransmit count is therefore fully predictable.

// File: rtl/rft_pkg.sv
package rft_pkg;
  localparam int HDR_BYTES = 16;
  localparam logic [15:0] FRAME_TYPE = 16'hFADE;
  localparam int SEQ_W = 16;
  typedef logic [SEQ_W-1:0] seq_t;
endpackage

// File: rtl/rft_buf.sv
module rft_buf #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data
);
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/rft_window.sv
module rft_window
  import rft_pkg::*;
#(
  parameter int WIN     = 4,
  parameter int WORDS   = 4,
  parameter int TIMEOUT = 1000,
  localparam int SW = $clog2(WIN),
  localparam int FW = $clog2(WORDS + 1),
  localparam int TW = $clog2(TIMEOUT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ack_vld,
  input  seq_t          ack_seq,
  input  logic          fill_en,
  input  logic          start_new,
  input  logic          start_re,
  output seq_t          nxt_seq,
  output logic [SW-1:0] nxt_slot,
  output logic [FW-1:0] fill,
  output logic          slot_free,
  output logic          frm_ready,
  output logic          re_any,
  output logic [SW-1:0] re_slot,
  output seq_t          re_seq
);
  logic [WIN-1:0] occ, expd;
  seq_t           slot_seq [WIN];

  assign nxt_slot = nxt_seq[SW-1:0];

  for (genvar g = 0; g < WIN; g++) begin : g_slot
    logic          occ_q, expd_q;
    logic [TW-1:0] tmr_q;
    seq_t          seq_q;
    logic          hit, load_new, load_re;

    assign hit      = ack_vld && occ_q && (seq_q == ack_seq);
    assign load_new = start_new && (nxt_slot == SW'(g));
    assign load_re  = start_re && (re_slot == SW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        occ_q  <= 1'b0;
        expd_q <= 1'b0;
        tmr_q  <= '0;
        seq_q  <= '0;
      end else begin
        if (occ_q && !expd_q) begin
          if (tmr_q == TW'(TIMEOUT - 1)) expd_q <= 1'b1;
          else                           tmr_q  <= tmr_q + 1'b1;
        end
        if (load_new) begin
          occ_q  <= 1'b1;
          seq_q  <= nxt_seq;
          tmr_q  <= '0;
          expd_q <= 1'b0;
        end
        if (load_re) begin
          expd_q <= 1'b0;
          tmr_q  <= '0;
        end
        if (hit) begin
          occ_q  <= 1'b0;
          expd_q <= 1'b0;
        end
      end
    end

    assign occ[g]      = occ_q;
    assign expd[g]     = expd_q;
    assign slot_seq[g] = seq_q;
  end

  // lowest-numbered expired slot is repeated first
  always_comb begin
    re_slot = '0;
    for (int i = WIN - 1; i >= 0; i--) begin
      if (expd[i]) re_slot = SW'(i);
    end
  end
  assign re_any = |expd;
  assign re_seq = slot_seq[re_slot];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nxt_seq <= '0;
      fill    <= '0;
    end else if (start_new) begin
      nxt_seq <= nxt_seq + 1'b1;
      fill    <= '0;
    end else if (fill_en) begin
      fill <= fill + 1'b1;
    end
  end

  assign slot_free = !occ[nxt_slot];
  assign frm_ready = (fill == FW'(WORDS));
endmodule

// File: rtl/rft_framer.sv
module rft_framer
  import rft_pkg::*;
#(
  parameter int          WORDS   = 4,
  parameter int          WIN     = 4,
  parameter int          GAP_W   = 16,
  parameter logic [47:0] DST_MAC = 48'h0,
  parameter logic [47:0] SRC_MAC = 48'h0,
  localparam int FLEN = HDR_BYTES + 4 * WORDS,
  localparam int IW   = $clog2(FLEN),
  localparam int SW   = $clog2(WIN),
  localparam int AW   = $clog2(WIN * WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SW-1:0]    st_slot,
  input  seq_t             st_seq,
  input  logic [GAP_W-1:0] gap_len,
  input  logic [31:0]      buf_word,
  output logic [AW-1:0]    rd_addr,
  output logic             busy,
  output logic [SW-1:0]    cur_slot,
  output logic             gap_ok,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [7:0]       tx_data,
  output logic             tx_first,
  output logic             tx_last
);
  logic [IW-1:0]    idx;
  seq_t             cur_seq;
  logic [GAP_W-1:0] gap_cnt;
  logic             last_hs;
  int               widx;

  assign tx_valid = busy;
  assign tx_first = busy && (idx == '0);
  assign tx_last  = busy && (idx == IW'(FLEN - 1));
  assign last_hs  = tx_last && tx_ready;
  assign gap_ok   = (gap_cnt == '0);

  always_comb begin
    int b;
    b = int'(idx);
    widx = (b < HDR_BYTES) ? 0 : (b - HDR_BYTES) / 4;
    tx_data = 8'h00;
    if (b < 6)       tx_data = DST_MAC[8*(5-b) +: 8];
    else if (b < 12) tx_data = SRC_MAC[8*(11-b) +: 8];
    else if (b == 12) tx_data = FRAME_TYPE[15:8];
    else if (b == 13) tx_data = FRAME_TYPE[7:0];
    else if (b == 14) tx_data = cur_seq[15:8];
    else if (b == 15) tx_data = cur_seq[7:0];
    else             tx_data = buf_word[8*(3-((b-HDR_BYTES)%4)) +: 8];
  end

  assign rd_addr = AW'(int'(cur_slot) * WORDS + widx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      idx      <= '0;
      cur_slot <= '0;
      cur_seq  <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      idx      <= '0;
      cur_slot <= st_slot;
      cur_seq  <= st_seq;
    end else if (busy && tx_ready) begin
      if (idx == IW'(FLEN - 1)) busy <= 1'b0;
      else                      idx  <= idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              gap_cnt <= '0;
    else if (last_hs)        gap_cnt <= gap_len;
    else if (gap_cnt != '0)  gap_cnt <= gap_cnt - 1'b1;
  end
endmodule

// File: rtl/rft_counters.sv
module rft_counters #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump_all,
  input  logic             bump_re,
  output logic [CNT_W-1:0] n_all,
  output logic [CNT_W-1:0] n_re,
  output logic             all_stb,
  output logic             re_stb
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_all   <= '0;
      n_re    <= '0;
      all_stb <= 1'b0;
      re_stb  <= 1'b0;
    end else begin
      all_stb <= bump_all;
      re_stb  <= bump_re;
      if (bump_all) n_all <= n_all + 1'b1;
      if (bump_re)  n_re  <= n_re + 1'b1;
    end
  end
endmodule

// File: rtl/rft_ack_tx.sv
module rft_ack_tx
  import rft_pkg::*;
#(
  parameter int          WORDS   = 4,
  parameter int          WIN     = 4,
  parameter int          TIMEOUT = 1000,
  parameter int          GAP_W   = 16,
  parameter int          CNT_W   = 32,
  parameter logic [47:0] DST_MAC = 48'h02_00_00_00_00_01,
  parameter logic [47:0] SRC_MAC = 48'h02_00_00_00_00_02
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din_valid,
  output logic             din_ready,
  input  logic [31:0]      din_data,
  input  logic             ack_vld,
  input  logic [15:0]      ack_seq,
  input  logic [GAP_W-1:0] gap_cycles,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [7:0]       tx_data,
  output logic             tx_first,
  output logic             tx_last,
  output logic [CNT_W-1:0] frames_sent,
  output logic             sent_stb,
  output logic [CNT_W-1:0] frames_resent,
  output logic             resent_stb
);
  localparam int SW = $clog2(WIN);
  localparam int FW = $clog2(WORDS + 1);
  localparam int AW = $clog2(WIN * WORDS);

  seq_t          nxt_seq, re_seq;
  logic [SW-1:0] nxt_slot, re_slot, cur_slot;
  logic [FW-1:0] fill;
  logic          slot_free, frm_ready, re_any, busy, gap_ok;
  logic          fill_en, start_new, start_re;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [31:0]   rd_word;

  assign din_ready = slot_free && (fill != FW'(WORDS)) && !(busy && cur_slot == nxt_slot);
  assign fill_en   = din_valid && din_ready;
  assign wr_addr   = AW'(int'(nxt_slot) * WORDS + int'(fill));
  assign start_re  = !busy && re_any;
  assign start_new = !busy && !re_any && frm_ready && gap_ok;

  rft_buf #(.DEPTH(WIN * WORDS)) u_buf (
    .clk(clk), .wr_en(fill_en), .wr_addr(wr_addr), .wr_data(din_data),
    .rd_addr(rd_addr), .rd_data(rd_word)
  );

  rft_window #(.WIN(WIN), .WORDS(WORDS), .TIMEOUT(TIMEOUT)) u_win (
    .clk(clk), .rst_n(rst_n), .ack_vld(ack_vld), .ack_seq(ack_seq),
    .fill_en(fill_en), .start_new(start_new), .start_re(start_re),
    .nxt_seq(nxt_seq), .nxt_slot(nxt_slot), .fill(fill),
    .slot_free(slot_free), .frm_ready(frm_ready),
    .re_any(re_any), .re_slot(re_slot), .re_seq(re_seq)
  );

  rft_framer #(
    .WORDS(WORDS), .WIN(WIN), .GAP_W(GAP_W),
    .DST_MAC(DST_MAC), .SRC_MAC(SRC_MAC)
  ) u_frm (
    .clk(clk), .rst_n(rst_n), .start(start_new || start_re),
    .st_slot(start_re ? re_slot : nxt_slot),
    .st_seq(start_re ? re_seq : nxt_seq),
    .gap_len(gap_cycles), .buf_word(rd_word), .rd_addr(rd_addr),
    .busy(busy), .cur_slot(cur_slot), .gap_ok(gap_ok),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_first(tx_first), .tx_last(tx_last)
  );

  rft_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .bump_all(start_new || start_re), .bump_re(start_re),
    .n_all(frames_sent), .n_re(frames_resent), .all_stb(sent_stb), .re_stb(resent_stb)
  );
endmodule

// File: rtl/rft_chk.sv
module rft_chk #(
  parameter logic [47:0] DST_MAC = 48'h0,
  parameter int          CNT_W   = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [7:0]       tx_data,
  input logic             tx_first,
  input logic             tx_last,
  input logic [CNT_W-1:0] frames_sent,
  input logic [CNT_W-1:0] frames_resent,
  input logic             sent_stb,
  input logic             resent_stb
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_first) && $stable(tx_last));

  p_first_dst_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_first |-> tx_data == DST_MAC[47:40]);

  p_first_not_last_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !(tx_first && tx_last));

  p_idle_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_last |=> !tx_valid);

  p_cnt_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sent_stb |-> frames_sent == $past(frames_sent) + 1'b1);

  p_re_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
    resent_stb |-> sent_stb);

  p_stb_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sent_stb |=> !sent_stb);

  p_re_le_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frames_resent <= frames_sent);
endmodule

bind rft_ack_tx rft_chk #(.DST_MAC(DST_MAC), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .tx_first(tx_first), .tx_last(tx_last),
  .frames_sent(frames_sent), .frames_resent(frames_resent),
  .sent_stb(sent_stb), .resent_stb(resent_stb)
);

// File: tb/tb_rft_ack_tx.sv
module tb_rft_ack_tx;
  localparam int          WORDS = 4;
  localparam int          TMO   = 400;
  localparam int          FLEN  = 16 + 4 * WORDS;
  localparam logic [47:0] B_DST = 48'hA1_B2_C3_D4_E5_F6;
  localparam logic [47:0] B_SRC = 48'h02_11_22_33_44_55;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        din_valid, din_ready;
  logic [31:0] din_data;
  logic        ack_vld;
  logic [15:0] ack_seq;
  logic [15:0] gap_cycles;
  logic        tx_valid, tx_ready, tx_first, tx_last;
  logic [7:0]  tx_data;
  logic [31:0] frames_sent, frames_resent;
  logic        sent_stb, resent_stb;

  always #5 clk = ~clk;

  rft_ack_tx #(
    .WORDS(WORDS), .WIN(4), .TIMEOUT(TMO), .GAP_W(16), .CNT_W(32),
    .DST_MAC(B_DST), .SRC_MAC(B_SRC)
  ) dut (
    .clk(clk), .rst_n(rst_n), .din_valid(din_valid), .din_ready(din_ready),
    .din_data(din_data), .ack_vld(ack_vld), .ack_seq(ack_seq),
    .gap_cycles(gap_cycles), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_first(tx_first), .tx_last(tx_last),
    .frames_sent(frames_sent), .sent_stb(sent_stb),
    .frames_resent(frames_resent), .resent_stb(resent_stb)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int exp_q[$];
  int cyc = 0, frames_done = 0, fpos = 0;
  int first_cyc[32], last_cyc[32];
  int hold_err = 0, stalls = 0, n_sent_stb = 0, n_re_stb = 0;
  bit bp_mode = 0, flag_err = 0;
  logic [7:0] fb[FLEN];
  logic prv_v = 0, prv_r = 0, prv_f = 0, prv_l = 0;
  logic [7:0] prv_d = 0;
  int word_ctr = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic logic [7:0] exp_byte(int s, int i);
    logic [31:0] w;
    logic [15:0] sq;
    sq = 16'(s);
    if (i < 6)   return B_DST[8*(5-i) +: 8];
    if (i < 12)  return B_SRC[8*(11-i) +: 8];
    if (i == 12) return 8'hFA;
    if (i == 13) return 8'hDE;
    if (i == 14) return sq[15:8];
    if (i == 15) return sq[7:0];
    w = 32'(s * WORDS + (i - 16) / 4);
    return w[8*(3-((i-16)%4)) +: 8];
  endfunction

  // scoreboard monitor: drives ready, then samples the stable outputs
  always @(negedge clk) begin
    cyc++;
    tx_ready = bp_mode ? (cyc % 3 != 0) : 1'b1;
    if (sent_stb)   n_sent_stb++;
    if (resent_stb) n_re_stb++;
    if (prv_v && !prv_r) begin
      stalls++;
      if (!(tx_valid && tx_data == prv_d && tx_first == prv_f && tx_last == prv_l)) hold_err++;
    end
    prv_v = tx_valid; prv_r = tx_ready; prv_d = tx_data; prv_f = tx_first; prv_l = tx_last;
    if (tx_valid && tx_ready) begin
      if (fpos == 0) begin first_cyc[frames_done % 32] = cyc; flag_err = 0; end
      if (tx_first != (fpos == 0) || tx_last != (fpos == FLEN - 1)) flag_err = 1;
      fb[fpos] = tx_data;
      if (fpos == FLEN - 1) begin
        int s, bad_i;
        last_cyc[frames_done % 32] = cyc;
        if (exp_q.size() == 0) begin
          chk("R3", "unexpected frame", 1, 0);
        end else begin
          s = exp_q.pop_front();
          bad_i = -1;
          for (int i = FLEN - 1; i >= 0; i--) if (fb[i] != exp_byte(s, i)) bad_i = i;
          if (bad_i >= 0)
            chk("R1/R3", $sformatf("frame seq %0d byte %0d", s, bad_i), fb[bad_i], exp_byte(s, bad_i));
          else
            chk("R1", $sformatf("first/last flags seq %0d", s), flag_err, 0);
        end
        frames_done++;
        fpos = 0;
      end else begin
        fpos++;
      end
    end
  end

  task automatic push_words(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      din_valid = 1'b1;
      din_data  = 32'(word_ctr);
      while (!din_ready) @(negedge clk);
      word_ctr++;
    end
    @(negedge clk);
    din_valid = 1'b0;
  endtask

  task automatic send_ack(int s);
    @(negedge clk);
    ack_vld = 1'b1;
    ack_seq = 16'(s);
    @(negedge clk);
    ack_vld = 1'b0;
  endtask

  task automatic wait_frames(int n);
    while (frames_done < n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; din_valid = 1'b0; din_data = '0;
    ack_vld = 1'b0; ack_seq = '0; gap_cycles = '0;
    repeat (3) @(negedge clk);
    chk("R10", "tx_valid in reset", tx_valid, 0);
    chk("R10", "din_ready in reset", din_ready, 1);
    chk("R10", "frames_sent in reset", frames_sent, 0);
    chk("R10", "frames_resent in reset", frames_resent, 0);
    rst_n = 1'b1;

    // four back-to-back frames fill the window
    for (int s = 0; s < 4; s++) exp_q.push_back(s);
    push_words(16);
    wait_frames(4);
    @(negedge clk);
    chk("R4", "din_ready with window full", din_ready, 0);
    chk("R9", "frames_sent after four", frames_sent, 4);
    begin
      int busy_cyc = 0;
      repeat (40) begin @(negedge clk); if (tx_valid || din_ready) busy_cyc++; end
      chk("R4", "activity while window full", busy_cyc, 0);
    end
    send_ack(9);
    repeat (3) @(negedge clk);
    chk("R6", "din_ready after stray ack", din_ready, 0);
    chk("R6", "frames_sent after stray ack", frames_sent, 4);
    send_ack(0);
    chk("R5", "din_ready after ack 0", din_ready, 1);
    for (int s = 1; s < 4; s++) send_ack(s);

    // frame 4 left unacknowledged until it is repeated
    exp_q.push_back(4); exp_q.push_back(4);
    push_words(4);
    wait_frames(6);
    chk("R7", "cycles between first bytes", first_cyc[5] - first_cyc[4], TMO + 1);
    chk("R9", "frames_resent after timeout", frames_resent, 1);
    chk("R9", "frames_sent after timeout", frames_sent, 6);
    send_ack(4);

    // back-pressure from the MAC
    bp_mode = 1;
    exp_q.push_back(5); exp_q.push_back(6);
    push_words(8);
    wait_frames(8);
    bp_mode = 0;
    chk("R2", "stalls observed", stalls > 0, 1);
    chk("R2", "hold violations", hold_err, 0);
    send_ack(5); send_ack(6);

    // inter-frame gap for new frames
    gap_cycles = 16'd20;
    exp_q.push_back(7); exp_q.push_back(8);
    push_words(8);
    wait_frames(10);
    chk("R8", "last byte to next first byte", first_cyc[9] - last_cyc[8], 22);
    send_ack(7); send_ack(8);
    send_ack(7);
    repeat (2) @(negedge clk);
    chk("R6", "frames_sent after duplicate ack", frames_sent, 10);
    chk("R5", "din_ready after all acks", din_ready, 1);
    chk("R9", "frames_resent final", frames_resent, 1);
    chk("R9", "sent strobes", n_sent_stb, 10);
    chk("R9", "resent strobes", n_re_stb, 1);
    chk("R3", "expected frames left", exp_q.size(), 0);
    finish_run();
  end
endmodule